// File: doc/BRIEF.md
# Shift-Add Twiddle Rotator for a 16-Point Radix-4 Stage

This block rotates a stream of complex 16-bit samples by the twiddle factors of a 16-point, radix-4 FFT stage, and it uses no hardware multiplier. Each constant cosine magnitude (1, cos(π/8), cos(π/4), cos(3π/8)) is built as a fixed sum of shifted copies of the operand. One such network per input component serves both the cosine and the sine term, because the sine of an angle equals the cosine of its complement. Real and imaginary selectors then pick a magnitude and a sign for each term.

A small cycle controller tracks the position of each valid sample inside a 16-sample frame. It derives the twiddle exponent from that position as (row × column), with row = position div 4 and column = position mod 4. A frame-start pulse restarts the position count. The datapath is two register stages deep, and the valid flag travels through the same stages as the data.

Top module: `twd_shiftadd_mult`

## Requirements
- R1: For a valid input (re, im) with exponent e, the output is re·cosθ + im·sinθ (real) and im·cosθ − re·sinθ (imaginary), with θ = 2πe/16. Each part is within 2 LSB of the ideal value after rounding and saturation to 16-bit two's complement.
- R2: The sample at frame position p (0..15) is rotated with exponent (p div 4)·(p mod 4). Only the exponents 0, 1, 2, 3, 4, 6 and 9 occur.
- R3: When frame_start is high together with in_valid, that sample takes position 0. When frame_start is high without in_valid, the next valid sample takes position 0. Without frame_start, the position runs from 15 back to 0.
- R4: Cycles with in_valid low do not advance the frame position. A stream with gaps is rotated exactly as the same samples would be without gaps.
- R5: out_valid equals in_valid delayed by two clock cycles. The result for a sample is on out_re/out_im while out_valid is high.
- R6: With exponent 0 the output equals the input bit for bit, including the value −32768.
- R7: With exponent 4 the output is exact: out_re = in_im and out_im = −in_re, where −(−32768) gives 32767.
- R8: A result whose ideal value lies above 32767 or below −32768 is clamped to 32767 or −32768.
- R9: While rst_n is low at a clock edge, out_valid, out_re and out_im go to 0 and the frame position returns to 0. The first valid sample after reset therefore takes position 0 even without frame_start.
- R10: While out_valid is low, out_re and out_im keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Restarts the frame position count |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_re | input | 16 | Input real part, two's complement |
| in_im | input | 16 | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample is valid this cycle |
| out_re | output | 16 | Rotated real part, two's complement |
| out_im | output | 16 | Rotated imaginary part, two's complement |

## Verification
The exponent is never visible at the ports. It follows only from how many valid samples have passed since the last frame start. The hardest cases to set up are therefore the position-dependent ones: the exact swap-and-negate at exponent 4 with a most-negative operand, and a frame restart requested in a cycle without data. The stimulus places full-scale and most-negative value pairs in every position of a frame. It then inserts idle gaps of varying length and restarts frames mid-stream and from idle cycles. The bench keeps its own position count and reads the exponent from it.

// File: rtl/twd_pkg.sv
// Shared constants, types and helpers of the shift-add twiddle rotator.
// Assumes a 16-point twiddle set: angles are in units of 2*pi/16 and the
// folded magnitude index m selects cos(m*pi/8), m = 0..4.
package twd_pkg;

    // Fraction bits of the shift-add products (largest right shift used)
    localparam int FRAC  = 14;
    // Magnitude indices 0..4: 1, cos(pi/8), cos(pi/4), cos(3pi/8), 0
    localparam int NMAG  = 5;
    // Shift-add networks for the three non-trivial magnitudes
    localparam int NNET  = 3;
    localparam int NTERM = 6;

    // Right-shift amount of each term, one row per network (index m-1)
    localparam int TERM_SHIFT [NNET][NTERM] = '{
        '{0, 4, 7, 8, 9, 14},   // 0.92389 = 1-2^-4-2^-7-2^-8-2^-9+2^-14
        '{1, 3, 4, 6, 8, 14},   // 0.70709
        '{2, 3, 7, 13, 0, 0}    // 0.38269 = 2^-2+2^-3+2^-7-2^-13
    };
    // Sign of each term: +1 add, -1 subtract, 0 unused
    localparam int TERM_SIGN [NNET][NTERM] = '{
        '{1, -1, -1, -1, -1, 1},
        '{1,  1,  1,  1,  1, 1},
        '{1,  1,  1, -1,  0, 0}
    };

    // Magnitude index plus sign of one coefficient
    typedef struct packed {
        logic [2:0] mag;
        logic       neg;
    } coef_sel_t;

    // Fold a 16-point angle onto the first quadrant: cos(a*2pi/16) = +/-cos(mag*pi/8)
    function automatic coef_sel_t fold_angle(input logic [3:0] a);
        coef_sel_t s;
        if (a <= 4'd4) begin
            s.mag = a[2:0];
            s.neg = 1'b0;
        end else if (a <= 4'd8) begin
            s.mag = 3'(4'd8 - a);
            s.neg = 1'b1;
        end else if (a <= 4'd12) begin
            s.mag = 3'(a - 4'd8);
            s.neg = 1'b1;
        end else begin
            s.mag = 3'(5'd16 - {1'b0, a});
            s.neg = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/twd_seq_ctrl.sv
// Cycle controller: tracks the position of each valid sample in the frame
// and produces the twiddle exponent (row * column) for the sample now on
// the input. Assumes PTS and RDX are powers of two with PTS = RDX*RDX.
module twd_seq_ctrl #(
    parameter int PTS = 16,
    parameter int RDX = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_start,
    input  logic                         in_valid,
    output logic [2*$clog2(RDX)-1:0]     exp_o
);
    localparam int IDXW = $clog2(PTS);
    localparam int CW   = $clog2(RDX);
    localparam int RW   = IDXW - CW;
    localparam int EXW  = 2 * CW;

    logic [IDXW-1:0] cnt_q;
    logic [IDXW-1:0] idx_cur;
    logic [RW-1:0]   row;
    logic [CW-1:0]   col;

    assign idx_cur = frame_start ? '0 : cnt_q;
    assign row     = idx_cur[IDXW-1:CW];
    assign col     = idx_cur[CW-1:0];

    // Position counter: advances on valid samples, restarts on frame_start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= IDXW'(idx_cur + 1'b1);
        end else if (frame_start) begin
            cnt_q <= '0;
        end
    end

    // Exponent = row * column, built by shift-and-add over the column bits
    always_comb begin
        exp_o = '0;
        for (int b = 0; b < CW; b++) begin
            if (col[b]) begin
                exp_o = EXW'(exp_o + (EXW'(row) << b));
            end
        end
    end

endmodule

// File: rtl/twd_shiftadd_bank.sv
// Constant-coefficient bank: forms x times each cosine magnitude as a fixed
// sum of shifted copies of x, scaled by 2^FRAC. Slot 0 is x*1 and the last
// slot is zero. The same bank feeds both the cosine and sine selectors.
module twd_shiftadd_bank
    import twd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0]                    x,
    output logic [NMAG-1:0][DW+FRAC:0]              prod
);
    localparam int PW = DW + FRAC + 1;

    logic signed [PW-1:0] xe;

    assign xe      = PW'(x);
    assign prod[0] = xe <<< FRAC;
    assign prod[NMAG-1] = '0;

    for (genvar g = 0; g < NNET; g++) begin : g_net
        logic signed [PW-1:0] acc;

        // Sum the signed, shifted terms of this constant
        always_comb begin
            acc = '0;
            for (int t = 0; t < NTERM; t++) begin
                if (TERM_SIGN[g][t] > 0) begin
                    acc = acc + (xe <<< (FRAC - TERM_SHIFT[g][t]));
                end else if (TERM_SIGN[g][t] < 0) begin
                    acc = acc - (xe <<< (FRAC - TERM_SHIFT[g][t]));
                end
            end
        end

        assign prod[g+1] = acc;
    end

endmodule

// File: rtl/twd_coef_select.sv
// Twiddle selector: picks one magnitude product from a bank and applies
// the coefficient sign by subtraction. Assumes sel.mag < NMAG.
module twd_coef_select
    import twd_pkg::*;
#(
    parameter int PW = 31
) (
    input  logic [NMAG-1:0][PW-1:0]  prod,
    input  coef_sel_t                sel,
    output logic signed [PW-1:0]     y
);
    logic signed [PW-1:0] mag_v;

    // Magnitude multiplexer over the bank slots
    always_comb begin
        mag_v = '0;
        for (int m = 0; m < NMAG; m++) begin
            if (sel.mag == 3'(m)) begin
                mag_v = $signed(prod[m]);
            end
        end
    end

    assign y = sel.neg ? -mag_v : mag_v;

endmodule

// File: rtl/twd_round_sat.sv
// Rounds a sum scaled by 2^FRAC to integer (half up) and clamps it to a
// DW-bit two's complement range. Assumes AW leaves headroom for the
// rounding constant.
module twd_round_sat #(
    parameter int DW   = 16,
    parameter int AW   = 32,
    parameter int FRAC = 14
) (
    input  logic signed [AW-1:0] acc,
    output logic signed [DW-1:0] y
);
    localparam logic signed [AW-1:0] HALF = AW'(64'sd1 <<< (FRAC - 1));
    localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

    logic signed [AW-1:0] rnd;

    assign rnd = (acc + HALF) >>> FRAC;

    // Clamp the rounded value into the output range
    always_comb begin
        if (rnd > MAXV) begin
            y = MAXV[DW-1:0];
        end else if (rnd < MINV) begin
            y = MINV[DW-1:0];
        end else begin
            y = rnd[DW-1:0];
        end
    end

endmodule

// File: rtl/twd_shiftadd_mult.sv
// Multiplier-free twiddle rotator for a 16-point radix-4 stage.
// Stage 1 registers the sample with the folded cosine/sine selections for
// its exponent. Stage 2 forms the shift-add products, combines them, then
// rounds and saturates into the output registers. Latency: two cycles.
// Assumes the default 16-point frame; the constant set is fixed to it.
module twd_shiftadd_mult
    import twd_pkg::*;
#(
    parameter int DW  = 16,
    parameter int PTS = 16,
    parameter int RDX = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);
    localparam int EXW = 2 * $clog2(RDX);
    localparam int PW  = DW + FRAC + 1;
    localparam int AW  = PW + 1;

    logic [EXW-1:0]       cur_exp;
    coef_sel_t            cos_sel_d, sin_sel_d;

    logic                 s1_valid;
    logic signed [DW-1:0] s1_re, s1_im;
    coef_sel_t            s1_cos, s1_sin;

    logic [NMAG-1:0][PW-1:0] bank_re, bank_im;
    logic signed [PW-1:0]    re_cos, re_sin, im_cos, im_sin;
    logic signed [AW-1:0]    acc_re, acc_im;
    logic signed [DW-1:0]    rs_re, rs_im;

    twd_seq_ctrl #(
        .PTS (PTS),
        .RDX (RDX)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .in_valid    (in_valid),
        .exp_o       (cur_exp)
    );

    // Cosine uses the angle, sine uses its complement (4 - a)
    assign cos_sel_d = fold_angle(4'(cur_exp));
    assign sin_sel_d = fold_angle(4'(4'd4 - 4'(cur_exp)));

    // Stage 1: capture the sample and its coefficient selections
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_re    <= '0;
            s1_im    <= '0;
            s1_cos   <= '0;
            s1_sin   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_re  <= in_re;
                s1_im  <= in_im;
                s1_cos <= cos_sel_d;
                s1_sin <= sin_sel_d;
            end
        end
    end

    twd_shiftadd_bank #(.DW(DW)) u_bank_re (.x(s1_re), .prod(bank_re));
    twd_shiftadd_bank #(.DW(DW)) u_bank_im (.x(s1_im), .prod(bank_im));

    twd_coef_select #(.PW(PW)) u_sel_re_cos (.prod(bank_re), .sel(s1_cos), .y(re_cos));
    twd_coef_select #(.PW(PW)) u_sel_re_sin (.prod(bank_re), .sel(s1_sin), .y(re_sin));
    twd_coef_select #(.PW(PW)) u_sel_im_cos (.prod(bank_im), .sel(s1_cos), .y(im_cos));
    twd_coef_select #(.PW(PW)) u_sel_im_sin (.prod(bank_im), .sel(s1_sin), .y(im_sin));

    assign acc_re = AW'(re_cos) + AW'(im_sin);
    assign acc_im = AW'(im_cos) - AW'(re_sin);

    twd_round_sat #(.DW(DW), .AW(AW), .FRAC(FRAC)) u_rs_re (.acc(acc_re), .y(rs_re));
    twd_round_sat #(.DW(DW), .AW(AW), .FRAC(FRAC)) u_rs_im (.acc(acc_im), .y(rs_im));

    // Stage 2: output registers, loaded only for valid samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_re <= rs_re;
                out_im <= rs_im;
            end
        end
    end

endmodule

// File: rtl/twd_checks.sv
// Property checker for the twiddle rotator, bound to every instance.
// Relates the ports over the two-cycle pipeline and watches the exponent
// produced by the cycle controller.
module twd_checks #(
    parameter int DW  = 16,
    parameter int EXW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_start,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_re,
    input logic signed [DW-1:0] in_im,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_re,
    input logic signed [DW-1:0] out_im,
    input logic [EXW-1:0]       cur_exp
);
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic [1:0] age_q;

    // Cycles since reset release, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R5

    AST_EXP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (cur_exp inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd9})); // R2

    AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frame_start) |-> (cur_exp == '0)); // R3

    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !frame_start) |=> (frame_start || $stable(cur_exp))); // R4

    AST_EXP0_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(in_valid, 2) && $past(cur_exp, 2) == '0) |->
        (out_re == $past(in_re, 2) && out_im == $past(in_im, 2))); // R6

    AST_EXP4_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(in_valid, 2) && $past(cur_exp, 2) == EXW'(4)) |->
        (out_re == $past(in_im, 2) &&
         out_im == (($past(in_re, 2) == MINV) ? MAXV : -$past(in_re, 2)))); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && !out_valid) |-> ($stable(out_re) && $stable(out_im))); // R10

endmodule

bind twd_shiftadd_mult twd_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_re       (in_re),
    .in_im       (in_im),
    .out_valid   (out_valid),
    .out_re      (out_re),
    .out_im      (out_im),
    .cur_exp     (cur_exp)
);

// File: tb/tb_twd_shiftadd_mult.sv
`timescale 1ns/1ps
module tb_twd_shiftadd_mult;

    localparam real PI = 3.141592653589793;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_re = '0;
    logic signed [15:0] in_im = '0;
    logic        out_valid;
    logic signed [15:0] out_re, out_im;

    twd_shiftadd_mult dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    int    pos = 0;
    string cur_tag = "";
    int    seed = 32'h1234_5678;

    // Expected-value delay line (two stages)
    bit    p0_v = 0, p1_v = 0;
    int    p0_re = 0, p0_im = 0, p1_re = 0, p1_im = 0;
    int    p0_tol = 0, p1_tol = 0;
    string p0_tag = "", p1_tag = "";
    bit    have_last = 0;
    int    last_re = 0, last_im = 0;

    function automatic int round_sat(real v);
        real f;
        f = $floor(v + 0.5);
        if (f > 32767.0) return 32767;
        if (f < -32768.0) return -32768;
        return $rtoi(f);
    endfunction

    task automatic check_val(string tag, string what, int got, int exp, int tol);
        n_chk++;
        if (got - exp > tol || exp - got > tol) begin
            n_bad++;
            $display("FAIL %s %s: got=%0d expected=%0d (tol %0d)", tag, what, got, exp, tol);
        end
    endtask

    // One clock: check outputs, then drive the next input and predict it
    task automatic step(bit v, bit fs, int r, int i);
        int  e;
        real c, s, vr, vi;
        @(negedge clk);
        check_val("R5", "out_valid", int'(out_valid), int'(p1_v), 0);
        if (p1_v) begin
            check_val(p1_tag, "out_re", int'(out_re), p1_re, p1_tol);
            check_val(p1_tag, "out_im", int'(out_im), p1_im, p1_tol);
            last_re = int'(out_re);
            last_im = int'(out_im);
            have_last = 1;
        end else if (have_last) begin
            check_val("R10", "held out_re", int'(out_re), last_re, 0);
            check_val("R10", "held out_im", int'(out_im), last_im, 0);
        end
        p1_v = p0_v; p1_re = p0_re; p1_im = p0_im; p1_tol = p0_tol; p1_tag = p0_tag;

        in_valid    = v;
        frame_start = fs;
        in_re       = 16'(r);
        in_im       = 16'(i);
        if (fs) pos = 0;
        p0_v = v;
        if (v) begin
            e  = (pos / 4) * (pos % 4);
            c  = $cos(2.0 * PI * e / 16.0);
            s  = $sin(2.0 * PI * e / 16.0);
            vr = r * c + i * s;
            vi = i * c - r * s;
            p0_re  = round_sat(vr);
            p0_im  = round_sat(vi);
            p0_tol = (e == 0 || e == 4) ? 0 : 2;
            if (cur_tag != "")                                 p0_tag = cur_tag;
            else if (e == 0)                                   p0_tag = "R6";
            else if (e == 4)                                   p0_tag = "R7";
            else if (vr > 32767.5 || vr < -32768.5 ||
                     vi > 32767.5 || vi < -32768.5)            p0_tag = "R8";
            else                                               p0_tag = "R1";
            pos = (pos + 1) % 16;
        end
    endtask

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return int'($signed(seed[24:9]));
    endfunction

    int corner [6] = '{32767, -32768, 0, 1, -1, 16384};

    initial begin
        // R9: outputs cleared while reset is held
        repeat (3) @(negedge clk);
        check_val("R9", "out_valid in reset", int'(out_valid), 0, 0);
        check_val("R9", "out_re in reset", int'(out_re), 0, 0);
        check_val("R9", "out_im in reset", int'(out_im), 0, 0);
        rst_n = 1'b1;

        // R9: first samples after reset take position 0.. without frame_start
        cur_tag = "R9";
        for (int k = 0; k < 4; k++) step(1, 0, 1234 - 999 * k, -567 + 321 * k);

        // R2: continue the frame with a pure real tone, then a pure imaginary one
        cur_tag = "R2";
        for (int k = 4; k < 16; k++) step(1, 0, 12000, 0);
        for (int k = 0; k < 16; k++) step(1, k == 0, 0, 12000);

        // R1: pseudo-random data over many frames; only the first has frame_start
        cur_tag = "";
        for (int k = 0; k < 384; k++) step(1, k == 0, next_rand(), next_rand());

        // R6/R7/R8: every corner pair in every frame position
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                for (int k = 0; k < 16; k++)
                    step(1, (a == 0 && b == 0 && k == 0), corner[a], corner[b]);

        // R4: a frame with idle gaps of 0..2 cycles between samples
        cur_tag = "R4";
        for (int k = 0; k < 16; k++) begin
            step(1, k == 0, 20000 - 2500 * k, -9000 + 1300 * k);
            for (int g = 0; g < k % 3; g++) step(0, 0, 7, 7);
        end

        // R3: restart mid-frame, then restart from an idle cycle
        cur_tag = "R3";
        for (int k = 0; k < 7; k++) step(1, 0, 3000, 4000);
        for (int k = 0; k < 16; k++) step(1, k == 0, -15000 + 1700 * k, 11000);
        for (int k = 0; k < 5; k++) step(1, 0, 5000, -5000);
        step(0, 1, 0, 0);
        for (int k = 0; k < 16; k++) step(1, 0, 8000, 8000 - 1000 * k);

        // R10: drain, outputs must hold once valid drops
        cur_tag = "R10";
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule